// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short shift register holding the outcomes of the most recent resolved branches. The value in that register picks one of several tables of saturating counters. A few low-order bits of the branch address pick the counter inside the chosen table. The fetch side presents an address and reads back a direction in the same cycle. The resolve side reports the real outcome of a branch, which moves the selected counter one step toward that outcome and shifts the outcome into the history.

With a history length of zero the block becomes a plain table of counters indexed by address. Entries carry no tag, so any two branches whose index bits match share one counter. The defaults are two history bits, two-bit counters and four index bits. That gives four tables of sixteen counters, 128 bits of state in all.

Top module: `corr_branch_predictor`

## Requirements
- R1: While the reset input is low, every counter holds the weakly-not-taken value 2^(CTR_BITS-1)-1 and the history holds zero, so every address predicts not taken. Asserting reset takes effect at once. Release is delayed by a two-stage synchronizer.
- R2: `pred_taken` follows `fetch_pc` combinationally. It is the most significant bit of the counter found at table number = history value, entry = `fetch_pc[IDX_LSB+IDX_BITS-1:IDX_LSB]` (bits 5:2 by default). A value of 1 means taken.
- R3: A resolved taken branch adds one to its counter, and the counter stops at 2^CTR_BITS-1. A resolved not-taken branch subtracts one, and the counter stops at 0.
- R4: With two-bit counters, the predicted direction from a saturated counter reverses only after two consecutive outcomes against it. A single contrary outcome leaves the prediction unchanged.
- R5: Each resolved branch shifts its outcome (1 = taken) into the history at bit 0. The older bits move one place up and the oldest bit drops out. The history does not change without `res_valid`.
- R6: No tag is compared. Two addresses with equal index bits read and update the same counter.
- R7: A resolution is applied on the rising clock edge where `res_valid` is high. The counter it updates is picked by the history as it was before that edge's shift. The new state is visible to lookups right after the edge. Nothing changes while `res_valid` is low, whatever `res_pc` and `res_taken` hold.
- R8: With HIST_BITS = 0 there is a single table, so outcomes of other branches never change which counter a given address reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Predicted direction for `fetch_pc`, 1 = taken |
| res_valid | input | 1 | A branch outcome is presented this cycle |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | Actual outcome of the resolved branch, 1 = taken |

## Verification
A lookup needs no clock, so a prediction is due in the same cycle as its address. A resolution shows up on the first rising edge after it is presented, and a lookup in the following half period must already reflect both the counter step and the shifted history. The bench drives each stimulus on a falling edge and checks the prediction at the next falling edge, which is exactly one update edge later. Reset assertion is checked a nanosecond after the reset input falls. Release is checked only after waiting out the two synchronizer stages.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

  // Width of the history bus; a zero-length history still needs one wire.
  function automatic int unsigned cbp_sel_width(int unsigned hist_bits);
    return (hist_bits == 0) ? 1 : hist_bits;
  endfunction

  // Weakly-not-taken counter value: one below the midpoint.
  function automatic int unsigned cbp_weak_nt(int unsigned ctr_bits);
    return (1 << (ctr_bits - 1)) - 1;
  endfunction

endpackage

// File: rtl/cbp_reset_sync.sv
module cbp_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/cbp_history.sv
module cbp_history #(
  parameter int unsigned HIST_BITS = 2,
  parameter int unsigned SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             shift_bit,
  output logic [SEL_W-1:0] hist_o
);

  if (HIST_BITS == 0) begin : g_no_hist
    logic unused_hist_in;
    assign unused_hist_in = shift_en ^ shift_bit ^ clk ^ rst_n;
    assign hist_o = '0;
  end else begin : g_hist
    logic [HIST_BITS-1:0] hist_q;
    logic [HIST_BITS-1:0] hist_d;

    always_comb begin
      hist_d = hist_q;
      if (shift_en) begin
        hist_d = (hist_q << 1) | HIST_BITS'(shift_bit);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hist_q <= '0;
      else if (shift_en) hist_q <= hist_d;
    end

    assign hist_o = SEL_W'(hist_q);
  end

endmodule

// File: rtl/cbp_counter_bank.sv
module cbp_counter_bank
  import cbp_pkg::*;
#(
  parameter int unsigned NUM_TABLES = 4,
  parameter int unsigned TBL_W      = 2,
  parameter int unsigned IDX_BITS   = 4,
  parameter int unsigned CTR_BITS   = 2
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic [TBL_W-1:0]                           rd_tbl,
  input  logic [IDX_BITS-1:0]                        rd_idx,
  output logic [CTR_BITS-1:0]                        rd_ctr,
  input  logic                                       wr_en,
  input  logic [TBL_W-1:0]                           wr_tbl,
  input  logic [IDX_BITS-1:0]                        wr_idx,
  input  logic                                       wr_up,
  output logic [NUM_TABLES*(1<<IDX_BITS)*CTR_BITS-1:0] ctr_flat_o
);

  localparam int unsigned ENTRIES = 1 << IDX_BITS;
  localparam logic [CTR_BITS-1:0] CTR_MAX  = '1;
  localparam logic [CTR_BITS-1:0] CTR_INIT = CTR_BITS'(cbp_weak_nt(CTR_BITS));

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
    logic tbl_hit;
    assign tbl_hit = (NUM_TABLES == 1) ? 1'b1 : (wr_tbl == TBL_W'(t));

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic                wr_hit;
      logic [CTR_BITS-1:0] ctr_q;
      logic [CTR_BITS-1:0] ctr_d;

      assign wr_hit = wr_en && tbl_hit && (wr_idx == IDX_BITS'(i));

      always_comb begin
        ctr_d = ctr_q;
        if (wr_up) begin
          if (ctr_q != CTR_MAX) ctr_d = ctr_q + CTR_BITS'(1);
        end else begin
          if (ctr_q != '0) ctr_d = ctr_q - CTR_BITS'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctr_q <= CTR_INIT;
        else if (wr_hit) ctr_q <= ctr_d;
      end

      assign ctr_flat_o[(t*ENTRIES+i)*CTR_BITS +: CTR_BITS] = ctr_q;
    end
  end

  always_comb begin
    rd_ctr = '0;
    for (int t = 0; t < NUM_TABLES; t++) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (((NUM_TABLES == 1) || (rd_tbl == TBL_W'(t))) && (rd_idx == IDX_BITS'(i))) begin
          rd_ctr = ctr_flat_o[(t*ENTRIES+i)*CTR_BITS +: CTR_BITS];
        end
      end
    end
  end

endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor
  import cbp_pkg::*;
#(
  parameter int unsigned HIST_BITS = 2,
  parameter int unsigned CTR_BITS  = 2,
  parameter int unsigned IDX_BITS  = 4,
  parameter int unsigned IDX_LSB   = 2,
  parameter int unsigned PC_W      = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_taken,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken
);

  localparam int unsigned NUM_TABLES = 1 << HIST_BITS;
  localparam int unsigned SEL_W      = cbp_sel_width(HIST_BITS);
  localparam int unsigned ENTRIES    = 1 << IDX_BITS;
  localparam int unsigned FLAT_W     = NUM_TABLES * ENTRIES * CTR_BITS;

  logic                rst_n_sync;
  logic [IDX_BITS-1:0] fetch_idx;
  logic [IDX_BITS-1:0] res_idx;
  logic [SEL_W-1:0]    hist;
  logic [CTR_BITS-1:0] rd_ctr;
  logic [FLAT_W-1:0]   ctr_flat;
  logic                unused_bits;

  cbp_reset_sync u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_sync)
  );

  assign fetch_idx = fetch_pc[IDX_LSB +: IDX_BITS];
  assign res_idx   = res_pc[IDX_LSB +: IDX_BITS];

  cbp_history #(
    .HIST_BITS (HIST_BITS),
    .SEL_W     (SEL_W)
  ) u_history (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .shift_en  (res_valid),
    .shift_bit (res_taken),
    .hist_o    (hist)
  );

  cbp_counter_bank #(
    .NUM_TABLES (NUM_TABLES),
    .TBL_W      (SEL_W),
    .IDX_BITS   (IDX_BITS),
    .CTR_BITS   (CTR_BITS)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .rd_tbl     (hist),
    .rd_idx     (fetch_idx),
    .rd_ctr     (rd_ctr),
    .wr_en      (res_valid),
    .wr_tbl     (hist),
    .wr_idx     (res_idx),
    .wr_up      (res_taken),
    .ctr_flat_o (ctr_flat)
  );

  assign pred_taken  = rd_ctr[CTR_BITS-1];
  assign unused_bits = ^{fetch_pc, res_pc, ctr_flat};

endmodule

// File: rtl/cbp_checker.sv
module cbp_checker #(
  parameter int unsigned HIST_BITS = 2,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned IDX_BITS  = 4,
  parameter int unsigned CTR_BITS  = 2
) (
  input logic                                          clk,
  input logic                                          rst_n,
  input logic                                          res_valid,
  input logic                                          res_taken,
  input logic [IDX_BITS-1:0]                           res_idx,
  input logic [SEL_W-1:0]                              hist,
  input logic [((1<<HIST_BITS)<<IDX_BITS)*CTR_BITS-1:0] ctr_flat
);

  localparam int unsigned ADDR_W  = HIST_BITS + IDX_BITS;
  localparam int unsigned NUM_ENT = 1 << ADDR_W;
  localparam logic [CTR_BITS-1:0] CTR_MAX = '1;

  logic [CTR_BITS-1:0] ent [NUM_ENT];
  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    assign ent[e] = ctr_flat[e*CTR_BITS +: CTR_BITS];
  end

  logic [ADDR_W-1:0]   pos;
  logic [ADDR_W-1:0]   pos_q;
  logic [CTR_BITS-1:0] old_q;
  logic                taken_q;
  logic                valid_q;
  logic [CTR_BITS-1:0] cur;

  assign pos = ADDR_W'(res_idx) | (ADDR_W'(hist) << IDX_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      old_q   <= '0;
      taken_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      pos_q   <= pos;
      old_q   <= ent[pos];
      taken_q <= res_taken;
      valid_q <= res_valid;
    end
  end

  assign cur = ent[pos_q];

  AST_CTR_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && taken_q) |-> (cur == ((old_q == CTR_MAX) ? CTR_MAX : old_q + CTR_BITS'(1)))); // R3

  AST_CTR_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !taken_q) |-> (cur == ((old_q == '0) ? '0 : old_q - CTR_BITS'(1)))); // R3

  AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(ctr_flat)); // R7

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(hist)); // R5

  if (HIST_BITS > 0) begin : g_hist_chk
    AST_HIST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> (hist[0] == $past(res_taken))); // R5
  end

endmodule

bind corr_branch_predictor cbp_checker #(
  .HIST_BITS (HIST_BITS),
  .SEL_W     (SEL_W),
  .IDX_BITS  (IDX_BITS),
  .CTR_BITS  (CTR_BITS)
) u_cbp_checker (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .res_valid (res_valid),
  .res_taken (res_taken),
  .res_idx   (res_idx),
  .hist      (hist),
  .ctr_flat  (ctr_flat)
);

// File: tb/corr_branch_predictor_bench.sv
`timescale 1ns/1ps
module corr_branch_predictor_bench;

  logic        clk;
  logic        rst_n;
  logic [31:0] fetch_pc;
  logic        pred;
  logic        res_valid;
  logic [31:0] res_pc;
  logic        res_taken;

  logic [31:0] f_fetch_pc;
  logic        f_pred;
  logic        f_res_valid;
  logic [31:0] f_res_pc;
  logic        f_res_taken;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [31:0] PC_A  = 32'h0000_0010; // index 4
  localparam logic [31:0] PC_B  = 32'h0000_0024; // index 9
  localparam logic [31:0] PC_A2 = 32'h0000_0410; // index 4, alias of PC_A

  corr_branch_predictor u_corr_branch_predictor (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_pc   (fetch_pc),
    .pred_taken (pred),
    .res_valid  (res_valid),
    .res_pc     (res_pc),
    .res_taken  (res_taken)
  );

  corr_branch_predictor #(.HIST_BITS(0)) u_corr_branch_predictor_flat (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_pc   (f_fetch_pc),
    .pred_taken (f_pred),
    .res_valid  (f_res_valid),
    .res_pc     (f_res_pc),
    .res_taken  (f_res_taken)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {res_valid, res_pc, res_taken, fetch_pc, expected prediction after the edge}
  localparam int NVEC = 16;
  localparam logic [66:0] VEC [NVEC] = '{
    {1'b1, PC_A,  1'b1, PC_A,  1'b0}, // R5 hist 00->01, table 1 still weak
    {1'b1, PC_A,  1'b1, PC_A,  1'b0}, // R5 hist ->11
    {1'b1, PC_A,  1'b1, PC_A,  1'b1}, // R3 table 3 entry 4 -> 2
    {1'b1, PC_A,  1'b1, PC_A,  1'b1}, // R3 -> 3
    {1'b1, PC_A,  1'b1, PC_A,  1'b1}, // R3 saturates at 3
    {1'b1, PC_A,  1'b0, PC_A,  1'b0}, // R5 hist ->10, table 2 weak
    {1'b1, PC_B,  1'b0, PC_A,  1'b1}, // R5 hist ->00, table 0 entry 4 = 2
    {1'b0, PC_B,  1'b1, PC_A,  1'b1}, // R7 ignored resolve
    {1'b0, PC_A,  1'b0, PC_A2, 1'b1}, // R6 alias reads same entry
    {1'b1, PC_A2, 1'b0, PC_A,  1'b0}, // R6 alias update hits PC_A entry
    {1'b1, PC_B,  1'b0, PC_B,  1'b0}, // R3 table 0 entry 9 -> 0
    {1'b1, PC_B,  1'b0, PC_B,  1'b0}, // R3 saturates at 0
    {1'b1, PC_B,  1'b1, PC_B,  1'b0}, // R7 hist ->01, table 1 weak
    {1'b1, PC_B,  1'b1, PC_B,  1'b0}, // R7 hist ->11
    {1'b1, PC_B,  1'b1, PC_B,  1'b1}, // R3 table 3 entry 9 -> 2
    {1'b0, PC_B,  1'b0, PC_A,  1'b1}  // R2 table 3 entry 4 = 2
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic flat_step(input logic v, input logic [31:0] pc, input logic t, input logic [31:0] fpc);
    f_res_valid = v;
    f_res_pc    = pc;
    f_res_taken = t;
    f_fetch_pc  = fpc;
    @(negedge clk);
    f_res_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    fetch_pc = PC_A; res_valid = 1'b0; res_pc = '0; res_taken = 1'b0;
    f_fetch_pc = PC_A; f_res_valid = 1'b0; f_res_pc = '0; f_res_taken = 1'b0;
    repeat (3) @(negedge clk);

    fetch_pc = PC_A;  #1 check("R1", "reset pred A",  pred, 1'b0);
    fetch_pc = PC_B;  #1 check("R1", "reset pred B",  pred, 1'b0);
    fetch_pc = PC_A2; #1 check("R1", "reset pred A2", pred, 1'b0);

    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    fetch_pc = PC_A; #1 check("R1", "after release", pred, 1'b0);
    @(negedge clk);

    for (int k = 0; k < NVEC; k++) begin
      res_valid = VEC[k][66];
      res_pc    = VEC[k][65:34];
      res_taken = VEC[k][33];
      fetch_pc  = VEC[k][32:1];
      @(negedge clk);
      res_valid = 1'b0;
      check("R2/R3/R5/R6/R7", $sformatf("vector %0d", k), pred, VEC[k][0]);
    end

    // Single-table configuration
    flat_step(1'b1, PC_A, 1'b1, PC_A); check("R3", "flat A up to 2", f_pred, 1'b1);
    flat_step(1'b1, PC_B, 1'b1, PC_A); check("R8", "other branch no table switch", f_pred, 1'b1);
    flat_step(1'b1, PC_A, 1'b1, PC_A); check("R3", "flat A up to 3", f_pred, 1'b1);
    flat_step(1'b1, PC_A, 1'b0, PC_A); check("R4", "one miss keeps taken", f_pred, 1'b1);
    flat_step(1'b1, PC_A, 1'b0, PC_A); check("R4", "second miss flips", f_pred, 1'b0);
    flat_step(1'b1, PC_A, 1'b0, PC_A); check("R4", "down to 0", f_pred, 1'b0);
    flat_step(1'b1, PC_A, 1'b1, PC_A); check("R4", "one taken keeps not taken", f_pred, 1'b0);
    flat_step(1'b1, PC_A, 1'b1, PC_A); check("R4", "second taken flips", f_pred, 1'b1);

    // Asynchronous reset assertion mid-run
    fetch_pc = PC_A; #1 check("R1", "trained before reset", pred, 1'b1);
    #1 rst_n = 1'b0;
    #1 check("R1", "immediate reset", pred, 1'b0);
    f_fetch_pc = PC_A; check("R1", "flat immediate reset", f_pred, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "after second release", pred, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule